// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one 16-bit channel that sits beside a free-running timer counter. It works in one of two modes. In compare mode, software loads a threshold, and the channel drives an output whenever the counter reaches that threshold. In capture mode, the channel records the counter value when a rising edge arrives on its selected input.

On the compare side the threshold has two stages. One is a holding register that software writes. The other is an active register that the comparator reads. When preloading is on, the holding register is copied into the active register only on an update event. When preloading is off, a write reaches the active register at once. The output can either pulse for one cycle on a match or invert on each match.

On the capture side a 2-bit source select picks the input. It can be an external pin or an internal reference clock that has been divided down. The input passes through a two-flop synchronizer and then a rising-edge detector. A pending-capture flag marks that a value is waiting. An overrun flag marks that a value was overwritten before software read it.

Top module: `cc_channel`

## Requirements
- R1: While `rst` is high at a clock edge, the holding, active and capture registers are cleared to 0x0000, and `oc_o`, `cap_flag_o` and `ovr_flag_o` are cleared to 0.
- R2: In compare mode (`cap_mode_i`=0) with `preload_en_i`=0, a write sets both the holding and active registers at the next edge. The new value is visible on `rd_data_o` and is used for matching from the following cycle.
- R3: In compare mode with `preload_en_i`=1, a write changes only the holding register. The active register takes the holding value at the edge where `upd_i` is high.
- R4: In compare mode with `preload_en_i`=1, when a write and `upd_i` occur in the same cycle, the active register takes the old holding value. The written value stays in the holding register until the next update.
- R5: When `toggle_mode_i`=0, `oc_o` is 1 in the cycle after `cnt_i` equals the active register, and 0 after any cycle without a match.
- R6: When `toggle_mode_i`=1, `oc_o` inverts in the cycle after each match and holds its value otherwise.
- R7: In capture mode, a rising edge on the selected input is synchronized by two flops and then detected. The capture register takes the `cnt_i` value that is present just before the third clock edge after the input is first seen high. That value is readable on `rd_data_o`.
- R8: When `remap_i` is 2'b10, the capture input is `ref_clk_i`. When `remap_i` is 2'b00, 2'b01 or 2'b11, the capture input is `pin_i`. The input that is not selected has no effect.
- R9: A capture sets `cap_flag_o`. A cycle with `rd_en_i`=1 and no new capture clears it.
- R10: A capture while `cap_flag_o` is set, with no read in that cycle, sets `ovr_flag_o`. A read clears `ovr_flag_o`.
- R11: In capture mode, writes have no effect on the holding register, and `oc_o` is held at 0. `rd_data_o` shows the capture register in capture mode and the holding register in compare mode.
- R12: A change of `preload_en_i` on its own does not move the active register. It only changes how later writes are handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_mode_i | input | 1 | 1 selects capture mode, 0 selects compare mode |
| preload_en_i | input | 1 | Enables buffering of writes until the update event |
| toggle_mode_i | input | 1 | 1 makes the output invert on a match, 0 makes it pulse |
| remap_i | input | 2 | Capture source select; 2'b10 selects the reference clock |
| pin_i | input | 1 | External capture pin |
| ref_clk_i | input | 1 | Internal divided reference clock |
| cnt_i | input | 16 | Timer counter value |
| upd_i | input | 1 | Update event from the timer |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 16 | Software write data |
| rd_en_i | input | 1 | Software read strobe; clears the flags |
| rd_data_o | output | 16 | Holding register in compare mode, capture register in capture mode |
| oc_o | output | 1 | Compare output |
| cap_flag_o | output | 1 | A captured value is waiting to be read |
| ovr_flag_o | output | 1 | A captured value was overwritten before it was read |

## Verification
Some rules are checked by the assertions on every cycle:
- A direct write reaches the active register.
- The active register moves only on a direct write or a preloaded update.
- An update copies the holding value.
- The output responds to a match in both output modes.
- The captured value equals the counter.
- The flags set and clear as required.
- The output is forced low in capture mode.

Other behaviours can only be shown by the bench scenarios:
- The three-edge synchronizer latency.
- Which source each remap code selects.
- The pending value that survives a write in the same cycle as an update.
- The holding value that survives writes made in capture mode.

// File: rtl/cc_pkg.sv
package cc_pkg;
  // remap code that routes the internal reference clock to the capture input
  localparam logic [1:0] REMAP_REF = 2'b10;

  typedef enum logic {
    OC_PULSE  = 1'b0,
    OC_TOGGLE = 1'b1
  } oc_mode_e;
endpackage

// File: rtl/cc_input_sel.sv
module cc_input_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] remap_i,
  input  logic       pin_i,
  input  logic       ref_i,
  output logic       rise_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic                   raw;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_comb raw = (remap_i == cc_pkg::REMAP_REF) ? ref_i : pin_i;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[i] <= 1'b0;
        else     sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[TOP];
  end

  always_comb rise_o = sync_q[TOP] & ~last_q;
endmodule

// File: rtl/cc_compare.sv
module cc_compare #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         out_mode_i,
  input  logic         preload_en_i,
  input  logic         toggle_i,
  input  logic         upd_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] hold_o,
  output logic [W-1:0] act_o,
  output logic         oc_o
);
  logic [W-1:0] hold_q;
  logic [W-1:0] act_q;
  logic         oc_q;
  logic         match;

  // holding and active registers
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      act_q  <= '0;
    end else if (out_mode_i) begin
      if (wr_en_i) hold_q <= wr_data_i;
      if (preload_en_i) begin
        if (upd_i) act_q <= hold_q;
      end else if (wr_en_i) begin
        act_q <= wr_data_i;
      end
    end
  end

  always_comb match = (cnt_i == act_q);

  always_ff @(posedge clk) begin
    if (rst || !out_mode_i) begin
      oc_q <= 1'b0;
    end else if (cc_pkg::oc_mode_e'(toggle_i) == cc_pkg::OC_TOGGLE) begin
      if (match) oc_q <= ~oc_q;
    end else begin
      oc_q <= match;
    end
  end

  assign hold_o = hold_q;
  assign act_o  = act_q;
  assign oc_o   = oc_q;
endmodule

// File: rtl/cc_capture.sv
module cc_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_mode_i,
  input  logic         rise_i,
  input  logic         rd_en_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] cap_o,
  output logic         evt_o,
  output logic         flag_o,
  output logic         ovr_o
);
  logic [W-1:0] cap_q;
  logic         flag_q;
  logic         ovr_q;
  logic         evt;

  always_comb evt = cap_mode_i & rise_i;

  always_ff @(posedge clk) begin
    if (rst) cap_q <= '0;
    else if (evt) cap_q <= cnt_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (evt)          flag_q <= 1'b1;
      else if (rd_en_i) flag_q <= 1'b0;

      if (evt && flag_q && !rd_en_i) ovr_q <= 1'b1;
      else if (rd_en_i)              ovr_q <= 1'b0;
    end
  end

  assign cap_o  = cap_q;
  assign evt_o  = evt;
  assign flag_o = flag_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/cc_channel.sv
module cc_channel #(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_mode_i,
  input  logic         preload_en_i,
  input  logic         toggle_mode_i,
  input  logic [1:0]   remap_i,
  input  logic         pin_i,
  input  logic         ref_clk_i,
  input  logic [W-1:0] cnt_i,
  input  logic         upd_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_en_i,
  output logic [W-1:0] rd_data_o,
  output logic         oc_o,
  output logic         cap_flag_o,
  output logic         ovr_flag_o
);
  logic         rise_w;
  logic         cap_evt_w;
  logic [W-1:0] hold_w;
  logic [W-1:0] act_w;
  logic [W-1:0] cap_w;

  cc_input_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .remap_i (remap_i),
    .pin_i   (pin_i),
    .ref_i   (ref_clk_i),
    .rise_o  (rise_w)
  );

  cc_compare #(.W(W)) u_cmp (
    .clk          (clk),
    .rst          (rst),
    .out_mode_i   (~cap_mode_i),
    .preload_en_i (preload_en_i),
    .toggle_i     (toggle_mode_i),
    .upd_i        (upd_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .cnt_i        (cnt_i),
    .hold_o       (hold_w),
    .act_o        (act_w),
    .oc_o         (oc_o)
  );

  cc_capture #(.W(W)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .cap_mode_i (cap_mode_i),
    .rise_i     (rise_w),
    .rd_en_i    (rd_en_i),
    .cnt_i      (cnt_i),
    .cap_o      (cap_w),
    .evt_o      (cap_evt_w),
    .flag_o     (cap_flag_o),
    .ovr_o      (ovr_flag_o)
  );

  assign rd_data_o = cap_mode_i ? cap_w : hold_w;
endmodule

// File: rtl/cc_channel_chk.sv
module cc_channel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cap_mode_i,
  input logic         preload_en_i,
  input logic         toggle_mode_i,
  input logic         upd_i,
  input logic         wr_en_i,
  input logic [W-1:0] wr_data_i,
  input logic         rd_en_i,
  input logic [W-1:0] cnt_i,
  input logic [W-1:0] rd_data_o,
  input logic         oc_o,
  input logic         cap_flag_o,
  input logic         ovr_flag_o,
  input logic [W-1:0] act_w,
  input logic         cap_evt_w
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!oc_o && !cap_flag_o && !ovr_flag_o && act_w == '0));

  p_direct_r2: assert property (@(posedge clk) disable iff (rst)
    (!cap_mode_i && !preload_en_i && wr_en_i) |=> (act_w == $past(wr_data_i)));

  p_upd_copy_r3: assert property (@(posedge clk) disable iff (rst)
    (!cap_mode_i && preload_en_i && upd_i) |=> (act_w == $past(rd_data_o)));

  p_act_stable_r12: assert property (@(posedge clk) disable iff (rst)
    (cap_mode_i || (preload_en_i && !upd_i) || (!preload_en_i && !wr_en_i))
      |=> $stable(act_w));

  p_pulse_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (!cap_mode_i && !toggle_mode_i && cnt_i == act_w) |=> oc_o);

  p_pulse_lo_r5: assert property (@(posedge clk) disable iff (rst)
    (!cap_mode_i && !toggle_mode_i && cnt_i != act_w) |=> !oc_o);

  p_toggle_r6: assert property (@(posedge clk) disable iff (rst)
    (!cap_mode_i && toggle_mode_i && cnt_i == act_w) |=> (oc_o != $past(oc_o)));

  p_capval_r7: assert property (@(posedge clk) disable iff (rst)
    cap_evt_w |=> (!cap_mode_i || rd_data_o == $past(cnt_i)));

  p_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
    cap_evt_w |=> cap_flag_o);

  p_flag_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !cap_evt_w) |=> (!cap_flag_o && !ovr_flag_o));

  p_ovr_r10: assert property (@(posedge clk) disable iff (rst)
    (cap_evt_w && cap_flag_o && !rd_en_i) |=> ovr_flag_o);

  p_oc_low_r11: assert property (@(posedge clk) disable iff (rst)
    cap_mode_i |=> !oc_o);
endmodule

bind cc_channel cc_channel_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cap_mode_i    (cap_mode_i),
  .preload_en_i  (preload_en_i),
  .toggle_mode_i (toggle_mode_i),
  .upd_i         (upd_i),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .rd_en_i       (rd_en_i),
  .cnt_i         (cnt_i),
  .rd_data_o     (rd_data_o),
  .oc_o          (oc_o),
  .cap_flag_o    (cap_flag_o),
  .ovr_flag_o    (ovr_flag_o),
  .act_w         (act_w),
  .cap_evt_w     (cap_evt_w)
);

// File: tb/sim_cc_channel.sv
module sim_cc_channel;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cap_mode = 1'b0, preload_en = 1'b0, toggle_mode = 1'b0;
  logic [1:0]   remap = 2'b00;
  logic         pin = 1'b0, ref_clk = 1'b0, upd = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt = 16'd500;
  logic [W-1:0] rd_data;
  logic         oc, cap_flag, ovr_flag;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_channel #(.W(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .cap_mode_i(cap_mode), .preload_en_i(preload_en),
    .toggle_mode_i(toggle_mode), .remap_i(remap), .pin_i(pin), .ref_clk_i(ref_clk),
    .cnt_i(cnt), .upd_i(upd), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .oc_o(oc), .cap_flag_o(cap_flag), .ovr_flag_o(ovr_flag)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [W-1:0] v);
    wr_en = 1'b1; wr_data = v; tick(); wr_en = 1'b0;
  endtask

  task automatic read_clear();
    rd_en = 1'b1; tick(); rd_en = 1'b0;
  endtask

  task automatic t_reset();
    tick(2);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 oc", oc, 0);
    chk("R1 cap_flag", cap_flag, 0);
    chk("R1 ovr_flag", ovr_flag, 0);
    rst = 1'b0;
    tick();
  endtask

  task automatic t_direct();
    wr(16'd20);
    chk("R2 rd_data after write", rd_data, 20);
    cnt = 16'd20; tick();
    chk("R2 match on new value", oc, 1);
    cnt = 16'd21; tick();
    chk("R5 pulse lasts one cycle", oc, 0);
  endtask

  task automatic t_preload();
    preload_en = 1'b1;
    wr(16'd40);
    chk("R3 holding updated", rd_data, 40);
    cnt = 16'd40; tick();
    chk("R3 no match on pending value", oc, 0);
    cnt = 16'd20; tick();
    chk("R3 old active still used", oc, 1);
    cnt = 16'd0; upd = 1'b1; tick(); upd = 1'b0;
    cnt = 16'd40; tick();
    chk("R3 update moved value", oc, 1);
  endtask

  task automatic t_same_cycle();
    wr_en = 1'b1; wr_data = 16'd60; upd = 1'b1; cnt = 16'd0; tick();
    wr_en = 1'b0; upd = 1'b0;
    cnt = 16'd40; tick();
    chk("R4 active took old holding", oc, 1);
    cnt = 16'd60; tick();
    chk("R4 new value not yet active", oc, 0);
    chk("R4 new value pending", rd_data, 60);
    cnt = 16'd0; upd = 1'b1; tick(); upd = 1'b0;
    cnt = 16'd60; tick();
    chk("R4 pending value after next update", oc, 1);
  endtask

  task automatic t_preload_change();
    cnt = 16'd0;
    wr(16'd80);
    preload_en = 1'b0; tick();
    cnt = 16'd60; tick();
    chk("R12 active unchanged by enable change", oc, 1);
    cnt = 16'd80; tick();
    chk("R12 pending value not applied", oc, 0);
    wr(16'd90);
    cnt = 16'd90; tick();
    chk("R12 later write direct", oc, 1);
  endtask

  task automatic t_toggle();
    cnt = 16'd0; tick();
    chk("R5 low without match", oc, 0);
    toggle_mode = 1'b1;
    cnt = 16'd90; tick();
    chk("R6 first toggle", oc, 1);
    cnt = 16'd91; tick();
    chk("R6 hold without match", oc, 1);
    cnt = 16'd90; tick();
    chk("R6 second toggle", oc, 0);
    toggle_mode = 1'b0; cnt = 16'd0; tick();
  endtask

  task automatic t_capture();
    cap_mode = 1'b1; remap = 2'b00; pin = 1'b0; cnt = 16'd90; tick(3);
    chk("R11 oc low in capture mode", oc, 0);
    wr(16'd1234);
    chk("R11 nothing captured yet", rd_data, 0);
    chk("R9 flag clear initially", cap_flag, 0);
    pin = 1'b1; cnt = 16'd300; tick();
    cnt = 16'd301; tick();
    chk("R7 no capture before third edge", cap_flag, 0);
    cnt = 16'd302; tick();
    chk("R7 captured counter value", rd_data, 302);
    chk("R9 flag set", cap_flag, 1);
    read_clear();
    chk("R9 flag cleared by read", cap_flag, 0);
  endtask

  task automatic t_overcapture();
    pin = 1'b0; tick(3);
    pin = 1'b1; cnt = 16'd400; tick(3);
    chk("R10 first capture value", rd_data, 400);
    chk("R10 no overrun yet", ovr_flag, 0);
    pin = 1'b0; tick(3);
    pin = 1'b1; cnt = 16'd500; tick(3);
    chk("R10 second capture value", rd_data, 500);
    chk("R10 overrun set", ovr_flag, 1);
    read_clear();
    chk("R10 overrun cleared by read", ovr_flag, 0);
    chk("R10 flag cleared by read", cap_flag, 0);
  endtask

  task automatic t_remap();
    remap = 2'b10; pin = 1'b0; ref_clk = 1'b0; tick(3);
    pin = 1'b1; cnt = 16'd600; tick(4);
    chk("R8 pin ignored with code 10", rd_data, 500);
    chk("R8 no flag from pin with code 10", cap_flag, 0);
    ref_clk = 1'b1; cnt = 16'd700; tick(3);
    chk("R8 reference captured with code 10", rd_data, 700);
    read_clear();
    remap = 2'b11; pin = 1'b0; tick(3);
    ref_clk = 1'b0; tick();
    ref_clk = 1'b1; cnt = 16'd800; tick(4);
    chk("R8 reference ignored with code 11", rd_data, 700);
    pin = 1'b1; cnt = 16'd900; tick(3);
    chk("R8 pin captured with code 11", rd_data, 900);
    read_clear();
    remap = 2'b01; pin = 1'b0; tick(3);
    pin = 1'b1; cnt = 16'd950; tick(3);
    chk("R8 pin captured with code 01", rd_data, 950);
    cap_mode = 1'b0; tick();
    chk("R11 holding kept across capture-mode write", rd_data, 90);
  endtask

  initial begin
    t_reset();
    t_direct();
    t_preload();
    t_same_cycle();
    t_preload_change();
    t_toggle();
    t_capture();
    t_overcapture();
    t_remap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule